// File: doc/BRIEF.md
# Dual-Issue Pair Check Logic

This block sits between the fetch stage and the two issue ports of a dual-issue pipeline. Each cycle it receives a 64-bit fetch packet with two 32-bit instruction slots. The lower slot is the first slot and carries an integer-class instruction: an integer ALU operation, a load, a store or a branch. The upper slot is the second slot and carries a floating-point operation. The block decodes the class of each slot and the registers that slot reads and writes. It checks the sources against a one-bit-per-register busy scoreboard and checks the second slot against the first. It then grants issue to zero, one or both slots.

The grants follow a fixed order. The first slot issues on its own merits. The second slot can issue only alongside the first. The block also returns a fetch advance count of 0, 1 or 2 slots. Any slot that is not granted is presented again by fetch in the next cycle. A stall input holds back both grants. All three results are registered, so they appear one clock after the packet is sampled.

Top module: `dual_issue_ctl`

## Requirements
- R1: While rst_n is low, grant0, grant1 and advance are all 0.
- R2: Each slot word is decoded as follows: class = bits [31:29], rd = [25:21], rs1 = [20:16], rs2 = [15:11]. Slot 0 is pkt[31:0] and slot 1 is pkt[63:32]. The grants and the advance count are registered and reflect the inputs sampled at the previous rising clock edge.
- R3: Class codes are 0 = integer ALU, 1 = load, 2 = store, 3 = branch, 4 = FP operation. Codes 5 to 7 are reserved. A slot with a reserved class is never granted.
- R4: Source and destination use by class. Every legal class reads rs1. ALU, store, branch and FP also read rs2, but a load does not. ALU, load and FP write rd. Store and branch write nothing. A register a slot does not read or write plays no part in its hazard checks.
- R5: grant1 is only ever high in a cycle where grant0 is also high.
- R6: Slot 1 may be granted only when slot 0 holds class 0 to 3 and slot 1 holds class 4. For any other pairing, only slot 0 is considered.
- R7: A slot is not granted if busy[r] is 1 for any register r that the slot reads.
- R8: Slot 1 is not granted if either of its sources equals slot 0's rd and slot 0 writes rd.
- R9: Slot 1 is not granted if slot 0 writes rd and slot 0's rd equals slot 1's rd.
- R10: advance is 0 when neither slot is granted, 1 when only slot 0 is granted, and 2 when both are granted.
- R11: If stall is high, both grants are 0 in the following cycle.
- R12: If pkt_valid is low, both grants are 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pkt_valid | input | 1 | Fetch packet present |
| pkt | input | 64 | Two instruction slots; slot 0 is in the low half |
| busy | input | 32 | One pending-write bit per register |
| stall | input | 1 | Holds back both grants |
| grant0 | output | 1 | Slot 0 issues |
| grant1 | output | 1 | Slot 1 issues |
| advance | output | 2 | Number of slots by which fetch moves forward |

## Verification
The most delicate overlap is a single cycle in which a scoreboard conflict and an intra-pair conflict both apply to slot 1. It gets worse when slot 0 is itself blocked or stalled, so the same slot 1 is rejected for several reasons at once. The stimulus uses register indices drawn from a small range together with sparse busy vectors. This makes RAW, WAW and busy-source conflicts coincide often. Directed packets then separate each cause on its own: a load whose unread rs2 is busy, and a store whose rd matches slot 1's rd. Every cycle, a reference model derived from the rules above computes the expected grants and advance count, and the outputs are compared against it.

// File: rtl/dual_issue_pkg.sv
package dual_issue_pkg;
  localparam int unsigned REG_IDX_W = 5;
  localparam int unsigned NREG      = 1 << REG_IDX_W;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned SLOTS     = 2;
  localparam int unsigned ADV_W     = $clog2(SLOTS + 1);

  localparam logic [2:0] CLS_ALU    = 3'd0;
  localparam logic [2:0] CLS_LOAD   = 3'd1;
  localparam logic [2:0] CLS_STORE  = 3'd2;
  localparam logic [2:0] CLS_BRANCH = 3'd3;
  localparam logic [2:0] CLS_FP     = 3'd4;

  typedef struct packed {
    logic                 legal;
    logic                 int_class;
    logic                 fp_class;
    logic                 wr_rd;
    logic                 rd_rs1;
    logic                 rd_rs2;
    logic [REG_IDX_W-1:0] rd;
    logic [REG_IDX_W-1:0] rs1;
    logic [REG_IDX_W-1:0] rs2;
  } slot_info_t;
endpackage

// File: rtl/dual_issue_slot_decode.sv
module dual_issue_slot_decode
  import dual_issue_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output slot_info_t        info
);
  logic [2:0] cls;
  logic       unused_bits;

  assign cls         = word[31:29];
  assign unused_bits = ^{word[28:26], word[10:0]};

  always_comb begin
    info           = '0;
    info.rd        = word[25:21];
    info.rs1       = word[20:16];
    info.rs2       = word[15:11];
    info.legal     = (cls <= CLS_FP);
    info.int_class = (cls <= CLS_BRANCH);
    info.fp_class  = (cls == CLS_FP);
    info.rd_rs1    = info.legal;
    info.rd_rs2    = info.legal && (cls != CLS_LOAD);
    info.wr_rd     = (cls == CLS_ALU) || (cls == CLS_LOAD) || (cls == CLS_FP);
  end
endmodule

// File: rtl/dual_issue_busy_check.sv
module dual_issue_busy_check
  import dual_issue_pkg::*;
(
  input  slot_info_t      info,
  input  logic [NREG-1:0] busy,
  output logic            src_busy
);
  always_comb begin
    src_busy = 1'b0;
    if (info.rd_rs1 && busy[info.rs1]) src_busy = 1'b1;
    if (info.rd_rs2 && busy[info.rs2]) src_busy = 1'b1;
  end
endmodule

// File: rtl/dual_issue_pair_check.sv
module dual_issue_pair_check
  import dual_issue_pkg::*;
(
  input  slot_info_t first,
  input  slot_info_t second,
  output logic       pair_block
);
  logic class_bad;
  logic raw_hit;
  logic waw_hit;

  always_comb begin
    class_bad  = !(first.int_class && second.fp_class);
    raw_hit    = first.wr_rd &&
                 ((second.rd_rs1 && (second.rs1 == first.rd)) ||
                  (second.rd_rs2 && (second.rs2 == first.rd)));
    waw_hit    = first.wr_rd && second.wr_rd && (second.rd == first.rd);
    pair_block = class_bad || raw_hit || waw_hit;
  end
endmodule

// File: rtl/dual_issue_ctl.sv
module dual_issue_ctl
  import dual_issue_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    pkt_valid,
  input  logic [SLOTS*WORD_W-1:0] pkt,
  input  logic [NREG-1:0]         busy,
  input  logic                    stall,
  output logic                    grant0,
  output logic                    grant1,
  output logic [ADV_W-1:0]        advance
);
  slot_info_t           info [SLOTS];
  logic [SLOTS-1:0]     src_busy;
  logic                 pair_block;

  logic                 grant0_d, grant1_d;
  logic [ADV_W-1:0]     advance_d;
  logic                 grant0_q, grant1_q;
  logic [ADV_W-1:0]     advance_q;

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    dual_issue_slot_decode u_dec (
      .word (pkt[s*WORD_W +: WORD_W]),
      .info (info[s])
    );
    dual_issue_busy_check u_busy (
      .info     (info[s]),
      .busy     (busy),
      .src_busy (src_busy[s])
    );
  end

  dual_issue_pair_check u_pair (
    .first      (info[0]),
    .second     (info[1]),
    .pair_block (pair_block)
  );

  always_comb begin
    grant0_d = pkt_valid && !stall && info[0].legal && !src_busy[0];
    grant1_d = grant0_d && info[1].legal && !src_busy[1] && !pair_block;
    case ({grant1_d, grant0_d})
      2'b01:   advance_d = ADV_W'(1);
      2'b11:   advance_d = ADV_W'(2);
      default: advance_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant0_q  <= 1'b0;
      grant1_q  <= 1'b0;
      advance_q <= '0;
    end else begin
      grant0_q  <= grant0_d;
      grant1_q  <= grant1_d;
      advance_q <= advance_d;
    end
  end

  assign grant0  = grant0_q;
  assign grant1  = grant1_q;
  assign advance = advance_q;
endmodule

// File: rtl/dual_issue_chk.sv
module dual_issue_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        pkt_valid,
  input logic        stall,
  input logic [2:0]  cls0,
  input logic [2:0]  cls1,
  input logic        grant0,
  input logic        grant1,
  input logic [1:0]  advance
);
  assert_slot1_needs_slot0_R5: assert property (@(posedge clk) disable iff (!rst_n)
    grant1 |-> grant0);

  assert_stall_blocks_R11: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> (!grant0 && !grant1));

  assert_idle_no_issue_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !pkt_valid |=> (advance == 2'd0));

  assert_pair_class_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && pkt_valid && !(cls0 <= 3'd3 && cls1 == 3'd4)) |=> !grant1);

  assert_reserved_class_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cls0 > 3'd4) |=> !grant0);

  assert_advance_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    advance != 2'd3);
endmodule

bind dual_issue_ctl dual_issue_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pkt_valid (pkt_valid),
  .stall     (stall),
  .cls0      (pkt[31:29]),
  .cls1      (pkt[63:61]),
  .grant0    (grant0),
  .grant1    (grant1),
  .advance   (advance)
);

// File: tb/sim_dual_issue_ctl.sv
module sim_dual_issue_ctl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        pkt_valid;
  logic [63:0] pkt;
  logic [31:0] busy;
  logic        stall;
  logic        grant0, grant1;
  logic [1:0]  advance;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  dual_issue_ctl u0 (
    .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt(pkt),
    .busy(busy), .stall(stall), .grant0(grant0), .grant1(grant1),
    .advance(advance)
  );

  function automatic logic [31:0] mk(input logic [2:0] c, input logic [4:0] rd,
                                     input logic [4:0] a, input logic [4:0] b);
    return {c, 3'b000, rd, a, b, 11'd0};
  endfunction

  function automatic logic [1:0] model(input logic pv, input logic st,
                                       input logic [63:0] p, input logic [31:0] bz);
    logic [2:0] c0, c1;
    logic [4:0] d0, a0, b0, d1, a1, b1;
    logic l0, l1, w0, w1, r20, r21, g0, g1;
    c0 = p[31:29]; d0 = p[25:21]; a0 = p[20:16]; b0 = p[15:11];
    c1 = p[63:61]; d1 = p[57:53]; a1 = p[52:48]; b1 = p[47:43];
    l0 = c0 <= 3'd4; l1 = c1 <= 3'd4;
    w0 = (c0 == 3'd0) || (c0 == 3'd1) || (c0 == 3'd4);
    w1 = (c1 == 3'd0) || (c1 == 3'd1) || (c1 == 3'd4);
    r20 = l0 && c0 != 3'd1; r21 = l1 && c1 != 3'd1;
    g0 = pv && !st && l0 && !(l0 && bz[a0]) && !(r20 && bz[b0]);
    g1 = g0 && c0 <= 3'd3 && c1 == 3'd4 && !bz[a1] && !(r21 && bz[b1]) &&
         !(w0 && (a1 == d0 || (r21 && b1 == d0))) && !(w0 && w1 && d1 == d0);
    return {g1, g0};
  endfunction

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got {g1,g0,adv}=%b expected %b", req, act, exp);
    end
  endtask

  task automatic step(input string req, input logic pv, input logic st,
                      input logic [63:0] p, input logic [31:0] bz);
    logic [1:0] g;
    pkt_valid = pv; stall = st; pkt = p; busy = bz;
    g = model(pv, st, p, bz);
    @(posedge clk); #2;
    check(req, {grant1, grant0, advance}, {g, (g == 2'b11) ? 2'd2 : (g == 2'b01) ? 2'd1 : 2'd0});
  endtask

  initial begin
    #150000;
    errors++;
    $display("FAIL watchdog: got hang expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'd2718);
    rst_n = 1'b0; pkt_valid = 1'b1; stall = 1'b0; busy = '0;
    pkt = {mk(3'd4, 5'd2, 5'd3, 5'd4), mk(3'd0, 5'd1, 5'd5, 5'd6)};
    #3; @(posedge clk); #2;
    check("R1 reset", {grant1, grant0, advance}, 4'b0000);
    @(negedge clk); rst_n = 1'b1;
    // R2 R10 clean pair issues both
    step("R2 R10 pair", 1, 0, {mk(3'd4, 5'd2, 5'd3, 5'd4), mk(3'd0, 5'd1, 5'd5, 5'd6)}, 0);
    // R3 reserved class in slot0
    step("R3 reserved", 1, 0, {mk(3'd4, 5'd2, 5'd3, 5'd4), mk(3'd6, 5'd1, 5'd5, 5'd6)}, 0);
    // R4 load ignores busy rs2
    step("R4 load rs2", 1, 0, {mk(3'd4, 5'd2, 5'd3, 5'd4), mk(3'd1, 5'd1, 5'd5, 5'd9)}, 32'h200);
    // R4 store writes nothing: same rd allowed
    step("R4 store rd", 1, 0, {mk(3'd4, 5'd7, 5'd3, 5'd4), mk(3'd2, 5'd7, 5'd5, 5'd6)}, 0);
    // R6 slot0 FP: only slot0
    step("R6 fp first", 1, 0, {mk(3'd4, 5'd2, 5'd3, 5'd4), mk(3'd4, 5'd1, 5'd5, 5'd6)}, 0);
    // R6 slot1 non-FP
    step("R6 int second", 1, 0, {mk(3'd0, 5'd2, 5'd3, 5'd4), mk(3'd0, 5'd1, 5'd5, 5'd6)}, 0);
    // R7 busy source on slot1 and slot0
    step("R7 busy s1", 1, 0, {mk(3'd4, 5'd2, 5'd3, 5'd4), mk(3'd0, 5'd1, 5'd5, 5'd6)}, 32'h10);
    step("R7 busy s0", 1, 0, {mk(3'd4, 5'd2, 5'd3, 5'd4), mk(3'd0, 5'd1, 5'd5, 5'd6)}, 32'h40);
    // R8 RAW on rs2; R9 WAW
    step("R8 raw", 1, 0, {mk(3'd4, 5'd2, 5'd3, 5'd1), mk(3'd0, 5'd1, 5'd5, 5'd6)}, 0);
    step("R9 waw", 1, 0, {mk(3'd4, 5'd1, 5'd3, 5'd4), mk(3'd1, 5'd1, 5'd5, 5'd6)}, 0);
    // R11 stall, R12 invalid
    step("R11 stall", 1, 1, {mk(3'd4, 5'd2, 5'd3, 5'd4), mk(3'd0, 5'd1, 5'd5, 5'd6)}, 0);
    step("R12 invalid", 0, 0, {mk(3'd4, 5'd2, 5'd3, 5'd4), mk(3'd0, 5'd1, 5'd5, 5'd6)}, 0);
    // random mix: R5 R6 R7 R8 R9 R10
    for (int i = 0; i < 3000; i++) begin
      logic [2:0] c0, c1;
      logic [31:0] bz;
      c0 = 3'($urandom_range(0, 5));
      c1 = ($urandom_range(0, 9) < 7) ? 3'd4 : 3'($urandom_range(0, 7));
      bz = $urandom & $urandom & $urandom;
      step("R5 R6 R7 R8 R9 R10 random", $urandom_range(0, 9) != 0, $urandom_range(0, 9) == 0,
           {mk(c1, 5'($urandom_range(0, 7)), 5'($urandom_range(0, 7)), 5'($urandom_range(0, 7))),
            mk(c0, 5'($urandom_range(0, 7)), 5'($urandom_range(0, 7)), 5'($urandom_range(0, 7)))},
           bz);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule